// File: doc/BRIEF.md
# DMA Destination Byte-Order Unit

This block sits on the write side of a single DMA channel, between the buffer data stream and destination memory. Each buffer begins with a start strobe that carries the buffer's byte count. The unit then accepts 64-bit beats and reorders their byte lanes according to a programmed byte-order mode. It emits each reordered beat with byte enables, a last-beat flag and a 4-bit access-type code that marks the write as a DMA access.

An 8-bit control register holds the byte-order mode and three access-type bits. The mode that steers the data path is a shadow copy. It reloads only when a new buffer is accepted, so software can reprogram the register at any time without disturbing a buffer already in progress.

A start strobe with a zero byte count is refused and flagged. Selecting the 32-bit word swap while the destination port is not 32 bits wide raises a configuration error, and the data then passes through unchanged.

Top module: `dst_byte_order`

## Requirements
- R1: After reset, `cfg_rdata` reads 0x10 (big-endian mode, access-type bits zero), and `out_valid`, `in_ready`, `err_zero` and `cfg_err` are all low.
- R2: A write on `cfg_we` stores `cfg_wdata[4:0]` at the next clock edge. Bits [4:3] hold the byte-order mode; bit 2, bit 1 and bit 0 are access-type bits A1, A2 and A3. Bits [7:5] always read as zero, whatever was written to them.
- R3: In modes 2'b10 and 2'b11 (big-endian), output lane i is input lane i. Lane i occupies bits [8i+7:8i], and lane 7 is the earliest byte.
- R4: In mode 2'b00 with `port_w32`=1, the bytes of each 32-bit word are reversed: output lane i takes input lane 4*(i/4)+3-(i%4).
- R5: In mode 2'b01, the bytes of each 64-bit double-word are reversed: output lane i takes input lane 7-i.
- R6: Every output beat carries `out_at` = {A3, A2, A1, 1}. Bit 0 is always 1, and the A bits come from the register value at the edge that accepts the beat.
- R7: The mode steering the data path is copied from the register only when a start strobe is accepted. A mode written during a buffer leaves the rest of that buffer unchanged and takes effect from the next buffer.
- R8: A start strobe with `in_count`=0 while idle raises `err_zero` for exactly one cycle after that edge. No transfer begins, and `in_ready` stays low.
- R9: A beat is accepted on an edge where `in_valid` and `in_ready` are both high, and it appears on the output one cycle later. `in_ready` = busy AND (NOT `out_valid` OR `out_ready`). While `out_valid` is high and `out_ready` is low, the output beat stays unchanged.
- R10: Each accepted beat consumes min(8, remaining) bytes. `out_last` is set on the beat where the remaining count is 8 or less, and `in_ready` drops after that beat. On a beat with k remaining bytes (k < 8), the valid input lanes are 7 down to 8-k, and `out_be` applies to those enables the same lane mapping as the data.
- R11: While the active mode is 2'b00 and `port_w32`=0, `cfg_err` is high, and data and enables pass through with output lane i equal to input lane i.
- R12: A start strobe that arrives while a buffer is still in progress is ignored: neither the remaining count nor the active mode changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register read value |
| port_w32 | input | 1 | Destination port is 32 bits wide |
| in_start | input | 1 | Buffer start strobe |
| in_count | input | CNT_W | Byte count of the buffer, sampled with `in_start` |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted on this edge if valid |
| in_data | input | 8*LANES | Input beat, lane 7 earliest |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Sink accepts the output beat |
| out_data | output | 8*LANES | Reordered beat |
| out_be | output | LANES | Byte enables of the reordered beat |
| out_last | output | 1 | Final beat of the buffer |
| out_at | output | 4 | Access-type code, bit 0 marks DMA |
| err_zero | output | 1 | Zero-length buffer refused |
| cfg_err | output | 1 | Word swap selected on a non-32-bit port |

## Verification
A register write shows on `cfg_rdata` one edge later. A start strobe updates `err_zero`, `cfg_err` and `in_ready` at the same next edge. An accepted beat appears on `out_data`, `out_be`, `out_last` and `out_at` exactly one edge after it is accepted. The bench changes inputs on the falling edge and reads every result at the following falling edge, so each check lands half a cycle after the edge that produced it. During the stall case, the bench holds `out_ready` low and reads the held beat on several successive falling edges.

// File: rtl/dbo_pkg.sv
package dbo_pkg;
  typedef enum logic [1:0] {
    BO_WSWAP = 2'b00,
    BO_DLE   = 2'b01,
    BO_BIG   = 2'b10,
    BO_BIG2  = 2'b11
  } bo_mode_e;

  localparam logic [4:0] CFG_RST = 5'b10000;
endpackage

// File: rtl/dbo_cfg_reg.sv
module dbo_cfg_reg
  import dbo_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [7:0]     wdata,
  output logic [7:0]     rdata,
  output bo_mode_e       live_mode,
  output logic [3:0]     at_code
);
  logic [4:0] cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (we) cfg_d = wdata[4:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= CFG_RST;
    else        cfg_q <= cfg_d;
  end

  assign rdata     = {3'b000, cfg_q};
  assign live_mode = bo_mode_e'(cfg_q[4:3]);
  // code bit 0 flags DMA; bits 1..3 take A1..A3 (register bits 2..0)
  assign at_code   = {cfg_q[0], cfg_q[1], cfg_q[2], 1'b1};
endmodule

// File: rtl/dbo_beat_ctl.sv
module dbo_beat_ctl
  import dbo_pkg::*;
#(
  parameter int LANES = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] count,
  input  bo_mode_e         live_mode,
  input  logic             accept,
  output logic             busy,
  output logic             last,
  output bo_mode_e         act_mode,
  output logic             err_zero,
  output logic [LANES-1:0] be_pre
);
  localparam logic [CNT_W-1:0] BEAT_BYTES = CNT_W'(LANES);

  logic [CNT_W-1:0] rem_q, rem_d;
  bo_mode_e         mode_q, mode_d;
  logic             err_q, err_d;
  logic             start_ok;

  assign busy     = (rem_q != '0);
  assign last     = (rem_q <= BEAT_BYTES);
  assign start_ok = start && !busy;

  always_comb begin
    rem_d  = rem_q;
    mode_d = mode_q;
    err_d  = start_ok && (count == '0);
    if (start_ok && (count != '0)) begin
      rem_d  = count;
      mode_d = live_mode;
    end else if (accept) begin
      rem_d = (rem_q > BEAT_BYTES) ? (rem_q - BEAT_BYTES) : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      mode_q <= BO_BIG;
      err_q  <= 1'b0;
    end else begin
      rem_q  <= rem_d;
      mode_q <= mode_d;
      err_q  <= err_d;
    end
  end

  // lane i is valid when at least LANES-i bytes remain (lane LANES-1 first)
  for (genvar i = 0; i < LANES; i++) begin : g_be
    assign be_pre[i] = (rem_q >= CNT_W'(LANES - i));
  end

  assign act_mode = mode_q;
  assign err_zero = err_q;
endmodule

// File: rtl/dbo_lane_map.sv
module dbo_lane_map
  import dbo_pkg::*;
#(
  parameter int LANES = 8
) (
  input  bo_mode_e           mode,
  input  logic               force_pass,
  input  logic [LANES*8-1:0] din,
  input  logic [LANES-1:0]   be_in,
  output logic [LANES*8-1:0] dout,
  output logic [LANES-1:0]   be_out
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int WSRC = (i / 4) * 4 + 3 - (i % 4);
    localparam int DSRC = (i / 8) * 8 + 7 - (i % 8);
    always_comb begin
      dout[i*8 +: 8] = din[i*8 +: 8];
      be_out[i]      = be_in[i];
      if (!force_pass) begin
        unique case (mode)
          BO_WSWAP: begin
            dout[i*8 +: 8] = din[WSRC*8 +: 8];
            be_out[i]      = be_in[WSRC];
          end
          BO_DLE: begin
            dout[i*8 +: 8] = din[DSRC*8 +: 8];
            be_out[i]      = be_in[DSRC];
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/dst_byte_order.sv
module dst_byte_order
  import dbo_pkg::*;
#(
  parameter int LANES = 8,
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [7:0]         cfg_wdata,
  output logic [7:0]         cfg_rdata,
  input  logic               port_w32,
  input  logic               in_start,
  input  logic [CNT_W-1:0]   in_count,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [LANES*8-1:0] in_data,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [LANES*8-1:0] out_data,
  output logic [LANES-1:0]   out_be,
  output logic               out_last,
  output logic [3:0]         out_at,
  output logic               err_zero,
  output logic               cfg_err
);
  localparam int DW = LANES * 8;

  bo_mode_e         live_mode, act_mode;
  logic [3:0]       at_code;
  logic             busy, last, accept;
  logic [LANES-1:0] be_pre, be_map;
  logic [DW-1:0]    data_map;

  dbo_cfg_reg i_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .live_mode(live_mode), .at_code(at_code)
  );

  dbo_beat_ctl #(.LANES(LANES), .CNT_W(CNT_W)) i_ctl (
    .clk(clk), .rst_n(rst_n), .start(in_start), .count(in_count),
    .live_mode(live_mode), .accept(accept), .busy(busy), .last(last),
    .act_mode(act_mode), .err_zero(err_zero), .be_pre(be_pre)
  );

  assign cfg_err = (act_mode == BO_WSWAP) && !port_w32;

  dbo_lane_map #(.LANES(LANES)) i_map (
    .mode(act_mode), .force_pass(cfg_err), .din(in_data), .be_in(be_pre),
    .dout(data_map), .be_out(be_map)
  );

  assign in_ready = busy && (!out_valid || out_ready);
  assign accept   = in_valid && in_ready;

  logic             ov_q, ov_d, ol_q, ol_d;
  logic [DW-1:0]    od_q, od_d;
  logic [LANES-1:0] ob_q, ob_d;
  logic [3:0]       oa_q, oa_d;

  always_comb begin
    ov_d = ov_q;
    od_d = od_q;
    ob_d = ob_q;
    ol_d = ol_q;
    oa_d = oa_q;
    if (accept) begin
      ov_d = 1'b1;
      od_d = data_map;
      ob_d = be_map;
      ol_d = last;
      oa_d = at_code;
    end else if (out_ready) begin
      ov_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_q <= 1'b0;
      od_q <= '0;
      ob_q <= '0;
      ol_q <= 1'b0;
      oa_q <= 4'b0001;
    end else begin
      ov_q <= ov_d;
      od_q <= od_d;
      ob_q <= ob_d;
      ol_q <= ol_d;
      oa_q <= oa_d;
    end
  end

  assign out_valid = ov_q;
  assign out_data  = od_q;
  assign out_be    = ob_q;
  assign out_last  = ol_q;
  assign out_at    = oa_q;
endmodule

// File: rtl/dst_byte_order_chk.sv
module dst_byte_order_chk #(
  parameter int LANES = 8,
  parameter int CNT_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic [7:0]         cfg_rdata,
  input logic               in_start,
  input logic [CNT_W-1:0]   in_count,
  input logic               in_ready,
  input logic               out_valid,
  input logic               out_ready,
  input logic [LANES*8-1:0] out_data,
  input logic [LANES-1:0]   out_be,
  input logic [3:0]         out_at,
  input logic               err_zero
);
  // R2
  rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[7:5] == 3'b000);
  // R6
  at_dma_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_at[0]);
  // R8
  zero_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_zero |-> ($past(in_start) && ($past(in_count) == '0) && !in_ready));
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_be)));
  // R10
  be_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_be != '0));
endmodule

bind dst_byte_order dst_byte_order_chk #(.LANES(LANES), .CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .cfg_rdata(cfg_rdata), .in_start(in_start),
  .in_count(in_count), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_be(out_be),
  .out_at(out_at), .err_zero(err_zero)
);

// File: tb/test_dst_byte_order.sv
module test_dst_byte_order;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic        port_w32 = 1'b1;
  logic        in_start = 1'b0;
  logic [15:0] in_count = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_data;
  logic [7:0]  out_be;
  logic        out_last;
  logic [3:0]  out_at;
  logic        err_zero;
  logic        cfg_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [7:0] cur_cfg = 8'h10;
  logic [1:0] exp_mode = 2'b10;

  always #10 clk = ~clk;

  dst_byte_order i_dst_byte_order (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int src_lane(logic [1:0] m, bit w32, int i);
    if (m[1]) return i;
    if (m == 2'b01) return 7 - i;
    if (!w32) return i;
    return (i / 4) * 4 + 3 - (i % 4);
  endfunction

  function automatic logic [63:0] exp_data(logic [1:0] m, bit w32, logic [63:0] d);
    logic [63:0] r;
    for (int i = 0; i < 8; i++) r[i*8 +: 8] = d[src_lane(m, w32, i)*8 +: 8];
    return r;
  endfunction

  function automatic logic [7:0] exp_be(logic [1:0] m, bit w32, int k);
    logic [7:0] pre, r;
    for (int i = 0; i < 8; i++) pre[i] = (i >= 8 - k);
    for (int i = 0; i < 8; i++) r[i] = pre[src_lane(m, w32, i)];
    return r;
  endfunction

  task automatic cfg_write(input logic [7:0] v);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    cur_cfg = {3'b000, v[4:0]};
  endtask

  task automatic start_buf(input int cnt, input bit expect_load);
    @(negedge clk);
    in_start = 1'b1;
    in_count = 16'(cnt);
    @(negedge clk);
    in_start = 1'b0;
    if (expect_load) exp_mode = cur_cfg[4:3];
  endtask

  task automatic push_beat(input logic [63:0] d, input int rem, input string req);
    int k;
    logic [3:0] at_e;
    k = (rem < 8) ? rem : 8;
    at_e = {cur_cfg[0], cur_cfg[1], cur_cfg[2], 1'b1};
    @(negedge clk);
    chk(in_ready == 1'b1, "R9 in_ready before beat", 64'(in_ready), 64'd1);
    in_valid = 1'b1;
    in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, "R9 out_valid one cycle later", 64'(out_valid), 64'd1);
    chk(out_data == exp_data(exp_mode, port_w32, d), req, out_data, exp_data(exp_mode, port_w32, d));
    chk(out_be == exp_be(exp_mode, port_w32, k), "R10 out_be", 64'(out_be), 64'(exp_be(exp_mode, port_w32, k)));
    chk(out_last == (rem <= 8), "R10 out_last", 64'(out_last), 64'(rem <= 8));
    chk(out_at == at_e, "R6 out_at", 64'(out_at), 64'(at_e));
  endtask

  function automatic string mode_req(logic [1:0] m, bit w32);
    if (m[1]) return "R3 big-endian data";
    if (m == 2'b01) return "R5 double-word reverse data";
    if (!w32) return "R11 pass-through on bad width";
    return "R4 word swap data";
  endfunction

  task automatic run_buf(input int cnt, input int mid_cfg, input bit mid_start);
    int rem;
    bit first;
    start_buf(cnt, 1'b1);
    chk(cfg_err == ((exp_mode == 2'b00) && !port_w32), "R11 cfg_err",
        64'(cfg_err), 64'((exp_mode == 2'b00) && !port_w32));
    rem = cnt;
    first = 1'b1;
    while (rem > 0) begin
      push_beat({$urandom, $urandom}, rem, mode_req(exp_mode, port_w32));
      rem = rem - ((rem < 8) ? rem : 8);
      if (first && rem > 0) begin
        if (mid_cfg >= 0) cfg_write(8'(mid_cfg));
        if (mid_start) start_buf(8, 1'b0);
      end
      first = 1'b0;
    end
    @(negedge clk);
    chk(in_ready == 1'b0, "R10 in_ready low after last", 64'(in_ready), 64'd0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    @(negedge clk);
    @(negedge clk);
    // R1 reset state
    chk(cfg_rdata == 8'h10, "R1 cfg_rdata reset", 64'(cfg_rdata), 64'h10);
    chk(out_valid == 0 && in_ready == 0 && err_zero == 0 && cfg_err == 0,
        "R1 outputs reset", 64'({out_valid, in_ready, err_zero, cfg_err}), 64'd0);
    rst_n = 1'b1;

    // R2 reserved bits read zero
    cfg_write(8'hFF);
    chk(cfg_rdata == 8'h1F, "R2 readback", 64'(cfg_rdata), 64'h1F);
    cfg_write(8'hA5);
    chk(cfg_rdata == 8'h05, "R2 readback", 64'(cfg_rdata), 64'h05);

    // R4 word swap, partial beat
    run_buf(13, -1, 1'b0);
    // R3 big-endian
    cfg_write(8'h12);
    run_buf(20, -1, 1'b0);
    // R5 double-word order, with R6 access type bits
    cfg_write(8'h0B);
    run_buf(8, -1, 1'b0);
    run_buf(3, -1, 1'b0);

    // R7 mid-buffer mode change deferred, R12 mid start ignored
    cfg_write(8'h10);
    run_buf(24, 8'h08, 1'b1);
    run_buf(16, -1, 1'b0);
    chk(exp_mode == 2'b01, "R7 new mode loaded", 64'(exp_mode), 64'd1);

    // R8 zero count
    @(negedge clk);
    in_start = 1'b1;
    in_count = 16'd0;
    @(negedge clk);
    in_start = 1'b0;
    chk(err_zero == 1'b1, "R8 err_zero raised", 64'(err_zero), 64'd1);
    chk(in_ready == 1'b0, "R8 no transfer", 64'(in_ready), 64'd0);
    in_valid = 1'b1;
    in_data = 64'h1122334455667788;
    @(negedge clk);
    in_valid = 1'b0;
    chk(err_zero == 1'b0, "R8 err_zero one cycle", 64'(err_zero), 64'd0);
    chk(out_valid == 1'b0, "R8 no beat output", 64'(out_valid), 64'd0);

    // R11 word swap on a non-32-bit port
    cfg_write(8'h00);
    port_w32 = 1'b0;
    run_buf(11, -1, 1'b0);
    port_w32 = 1'b1;

    // R9 stall holds the output beat
    cfg_write(8'h10);
    start_buf(16, 1'b1);
    out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b1;
    in_data = 64'h0102030405060708;
    @(negedge clk);
    in_valid = 1'b0;
    for (int c = 0; c < 3; c++) begin
      chk(out_valid == 1'b1 && out_data == 64'h0102030405060708, "R9 held beat",
          out_data, 64'h0102030405060708);
      chk(in_ready == 1'b0, "R9 in_ready low in stall", 64'(in_ready), 64'd0);
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R9 beat drained", 64'(out_valid), 64'd0);
    push_beat(64'hCAFEF00DDEADBEEF, 8, "R3 after stall");
    @(negedge clk);

    // random buffers
    for (int n = 0; n < 25; n++) begin
      cfg_write(8'($urandom));
      port_w32 = (($urandom % 4) != 0);
      run_buf(1 + int'($urandom % 40), -1, 1'b0);
    end

    done = 1;
    finish_run();
  end
endmodule